// File: doc/BRIEF.md
# Configurable Single-Port Synchronous RAM

This block is a synchronous single-port memory holding 16384 data bits. Its aspect ratio is fixed at build time. It can be 16384 entries of 1 bit, 4096 entries of 4 bits, or 1024 entries of 16 bits. The 16-bit shape also carries 2 parity bits per entry. Reads and writes both happen at the rising clock edge. The data output sits in a register, so read data shows up just after the edge that sampled the address, as with any flip-flop.

Build-time parameters set four things:
- the output value held while reset is active;
- the output value loaded by a synchronous set/reset input;
- what the output shows during a write: the new data, the old contents, or no change;
- the initial memory contents, given as packed 256-bit words.

The asynchronous active-low reset stands in for power-up. It loads the power-up output value and restores the initial contents. Its release is synchronised inside the block.

Top module: `bram_cfg`

## Requirements
- R1: The shape sets the address and data widths. The 1-bit shape has a 14-bit address. The 4-bit shape has a 12-bit address. The 16-bit shape has a 10-bit address and a 2-bit parity path on both input and output.
- R2: Bit j of init word k (k from 0 to 63, j from 0 to 255) is memory bit 256k+j. Entry a of a D-bit shape holds memory bits D*a up to D*a+D-1, with the least significant bit first. Parity init bit 256k+j holds parity bit j mod 2 of 16-bit entry (256k+j)/2.
- R3: On an edge with enable high, write low and set/reset low, the output takes the contents of the addressed entry. The value is visible just after that edge.
- R4: In write-first mode, an enabled write that is not a set/reset puts the written data (and parity) on the output at the same edge.
- R5: In read-first mode, an enabled write that is not a set/reset puts the contents from before the write on the output.
- R6: In no-change mode, an enabled write that is not a set/reset leaves the output at its previous value.
- R7: On an enabled edge with set/reset high, the output takes the set/reset value, with bits 17:16 as parity and the low bits as data. This overrides the read and the write-mode result. A write in that same cycle is still stored.
- R8: With enable low, the edge has no effect: no write is stored, set/reset is ignored and the output holds.
- R9: The output shows the power-up value while reset is low. It keeps that value after release until the first enabled edge. Reset restores the initial contents. Release takes effect after two clock edges.
- R10: The 16-bit shape stores parity beside the data and returns it with the data. The narrow shapes ignore the parity input and drive the parity output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset (power-up model), released synchronously |
| en | input | 1 | Enable for read, write and set/reset |
| we | input | 1 | Write strobe, qualified by en |
| sr | input | 1 | Synchronous set/reset of the output register, qualified by en |
| addr | input | AW (10/12/14) | Entry address; width follows the shape |
| din | input | DW (16/4/1) | Write data |
| pin | input | 2 | Write parity; used by the 16-bit shape only |
| dout | output | DW (16/4/1) | Registered read data |
| pout | output | 2 | Registered read parity; zero for narrow shapes |

## Verification
A wrong lane select or write mask corrupts the neighbouring entries in the same 16-bit physical word. This shows only when one of those entries is read back, one cycle after its read edge. The output register fault is visible right away: a wrong mode, set/reset priority or enable gate gives a wrong dout on the edge after the faulty operation. An init-mapping error shows on the first read of an affected address, so the bench sweeps every 1-bit entry after reset.

// File: rtl/bram_cfg_pkg.sv
package bram_cfg_pkg;

  typedef enum logic [1:0] {
    SHAPE_X1  = 2'd0,
    SHAPE_X4  = 2'd1,
    SHAPE_X16 = 2'd2
  } shape_e;

  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

  localparam int TOTAL_BITS  = 16384;
  localparam int PHYS_W      = 16;
  localparam int PHYS_DEPTH  = TOTAL_BITS / PHYS_W;
  localparam int PHYS_AW     = $clog2(PHYS_DEPTH);
  localparam int PAR_W       = 2;
  localparam int REG_W       = PHYS_W + PAR_W;
  localparam int INIT_WORD_W = 256;
  localparam int INIT_WORDS  = TOTAL_BITS / INIT_WORD_W;
  localparam int PINIT_WORDS = (PHYS_DEPTH * PAR_W) / INIT_WORD_W;

  function automatic int data_w(shape_e s);
    case (s)
      SHAPE_X1: return 1;
      SHAPE_X4: return 4;
      default:  return PHYS_W;
    endcase
  endfunction

  function automatic int addr_w(shape_e s);
    return $clog2(TOTAL_BITS / data_w(s));
  endfunction

endpackage

// File: rtl/bram_rst_sync.sv
module bram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // shift a one in; assertion is immediate, release waits STAGES edges
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q = sync_q[STAGES-1];

endmodule

// File: rtl/bram_lane_map.sv
module bram_lane_map
  import bram_cfg_pkg::*;
#(
  parameter shape_e SHAPE = SHAPE_X16,
  localparam int DW = data_w(SHAPE),
  localparam int AW = addr_w(SHAPE)
) (
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      din,
  input  logic [PAR_W-1:0]   pin,
  input  logic [PHYS_W-1:0]  rd_word,
  input  logic [PAR_W-1:0]   rd_par,
  output logic [PHYS_AW-1:0] word_idx,
  output logic [PHYS_W-1:0]  wr_data,
  output logic [PHYS_W-1:0]  wr_mask,
  output logic [PAR_W-1:0]   wr_par,
  output logic               par_wen,
  output logic [DW-1:0]      rd_lane,
  output logic [PAR_W-1:0]   rd_lane_par
);

  generate
    if (SHAPE == SHAPE_X16) begin : g_full
      // one entry per physical word, parity travels with it
      assign word_idx    = addr;
      assign wr_data     = din;
      assign wr_mask     = '1;
      assign wr_par      = pin;
      assign par_wen     = 1'b1;
      assign rd_lane     = rd_word;
      assign rd_lane_par = rd_par;
    end else begin : g_narrow
      localparam int LB    = AW - PHYS_AW;
      localparam int LANES = PHYS_W / DW;
      logic [LB-1:0] lane;
      logic          unused_par;

      // low address bits pick the lane, LSB lane first
      assign lane        = addr[LB-1:0];
      assign word_idx    = addr[AW-1:LB];
      assign wr_data     = {LANES{din}};
      assign wr_mask     = {{(PHYS_W-DW){1'b0}}, {DW{1'b1}}} << (int'(lane) * DW);
      assign wr_par      = '0;
      assign par_wen     = 1'b0;
      assign rd_lane     = rd_word[int'(lane)*DW +: DW];
      assign rd_lane_par = '0;
      assign unused_par  = ^{pin, rd_par};
    end
  endgenerate

endmodule

// File: rtl/bram_store.sv
module bram_store
  import bram_cfg_pkg::*;
#(
  parameter logic [INIT_WORDS-1:0][INIT_WORD_W-1:0]  INIT_DATA = '0,
  parameter logic [PINIT_WORDS-1:0][INIT_WORD_W-1:0] INIT_PAR  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wen,
  input  logic               par_wen,
  input  logic [PHYS_AW-1:0] idx,
  input  logic [PHYS_W-1:0]  wdata,
  input  logic [PHYS_W-1:0]  wmask,
  input  logic [PAR_W-1:0]   wpar,
  output logic [PHYS_W-1:0]  rd_word,
  output logic [PAR_W-1:0]   rd_par
);

  localparam logic [TOTAL_BITS-1:0]         INIT_FLAT  = INIT_DATA;
  localparam logic [PHYS_DEPTH*PAR_W-1:0]   PINIT_FLAT = INIT_PAR;

  logic [PHYS_W-1:0] mem_q [PHYS_DEPTH];
  logic [PAR_W-1:0]  par_q [PHYS_DEPTH];
  logic [PHYS_W-1:0] word_d;

  // contents before this edge's write
  assign rd_word = mem_q[idx];
  assign rd_par  = par_q[idx];

  always_comb begin
    word_d = (rd_word & ~wmask) | (wdata & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_DEPTH; i++) begin
        mem_q[i] <= INIT_FLAT[i*PHYS_W +: PHYS_W];
        par_q[i] <= PINIT_FLAT[i*PAR_W +: PAR_W];
      end
    end else begin
      if (wen) begin
        mem_q[idx] <= word_d;
      end
      if (wen && par_wen) begin
        par_q[idx] <= wpar;
      end
    end
  end

endmodule

// File: rtl/bram_out_stage.sv
module bram_out_stage
  import bram_cfg_pkg::*;
#(
  parameter int               DW      = 16,
  parameter bit               HAS_PAR = 1'b1,
  parameter wmode_e           WMODE   = WM_WRITE_FIRST,
  parameter logic [REG_W-1:0] PWR_VAL = '0,
  parameter logic [REG_W-1:0] SR_VAL  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             we,
  input  logic             sr,
  input  logic [DW-1:0]    old_data,
  input  logic [PAR_W-1:0] old_par,
  input  logic [DW-1:0]    new_data,
  input  logic [PAR_W-1:0] new_par,
  output logic [DW-1:0]    dout,
  output logic [PAR_W-1:0] pout
);

  localparam logic [DW-1:0]    PWR_D = PWR_VAL[DW-1:0];
  localparam logic [DW-1:0]    SR_D  = SR_VAL[DW-1:0];
  localparam logic [PAR_W-1:0] PWR_P = HAS_PAR ? PWR_VAL[REG_W-1:PHYS_W] : '0;
  localparam logic [PAR_W-1:0] SR_P  = HAS_PAR ? SR_VAL[REG_W-1:PHYS_W]  : '0;

  logic [DW-1:0]    d_q, d_d;
  logic [PAR_W-1:0] p_q, p_d;

  always_comb begin
    d_d = d_q;
    p_d = p_q;
    if (en) begin
      if (sr) begin
        d_d = SR_D;
        p_d = SR_P;
      end else if (!we) begin
        d_d = old_data;
        p_d = old_par;
      end else begin
        case (WMODE)
          WM_WRITE_FIRST: begin
            d_d = new_data;
            p_d = new_par;
          end
          WM_READ_FIRST: begin
            d_d = old_data;
            p_d = old_par;
          end
          default: begin
            d_d = d_q;
            p_d = p_q;
          end
        endcase
      end
    end
    if (!HAS_PAR) begin
      p_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= PWR_D;
      p_q <= PWR_P;
    end else begin
      d_q <= d_d;
      p_q <= p_d;
    end
  end

  assign dout = d_q;
  assign pout = p_q;

endmodule

// File: rtl/bram_cfg.sv
module bram_cfg
  import bram_cfg_pkg::*;
#(
  parameter shape_e           SHAPE   = SHAPE_X16,
  parameter wmode_e           WMODE   = WM_WRITE_FIRST,
  parameter logic [REG_W-1:0] PWR_VAL = '0,
  parameter logic [REG_W-1:0] SR_VAL  = '0,
  parameter logic [INIT_WORDS-1:0][INIT_WORD_W-1:0]  INIT_DATA = '0,
  parameter logic [PINIT_WORDS-1:0][INIT_WORD_W-1:0] INIT_PAR  = '0,
  localparam int DW = data_w(SHAPE),
  localparam int AW = addr_w(SHAPE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             we,
  input  logic             sr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic [PAR_W-1:0] pin,
  output logic [DW-1:0]    dout,
  output logic [PAR_W-1:0] pout
);

  logic               rst_q;
  logic               wen;
  logic [PHYS_AW-1:0] word_idx;
  logic [PHYS_W-1:0]  wr_data;
  logic [PHYS_W-1:0]  wr_mask;
  logic [PAR_W-1:0]   wr_par;
  logic               par_wen;
  logic [PHYS_W-1:0]  rd_word;
  logic [PAR_W-1:0]   rd_par;
  logic [DW-1:0]      rd_lane;
  logic [PAR_W-1:0]   rd_lane_par;

  // write is gated by enable only; set/reset does not block it
  assign wen = en & we;

  bram_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  bram_lane_map #(.SHAPE(SHAPE)) u_map (
    .addr        (addr),
    .din         (din),
    .pin         (pin),
    .rd_word     (rd_word),
    .rd_par      (rd_par),
    .word_idx    (word_idx),
    .wr_data     (wr_data),
    .wr_mask     (wr_mask),
    .wr_par      (wr_par),
    .par_wen     (par_wen),
    .rd_lane     (rd_lane),
    .rd_lane_par (rd_lane_par)
  );

  bram_store #(.INIT_DATA(INIT_DATA), .INIT_PAR(INIT_PAR)) u_store (
    .clk     (clk),
    .rst_n   (rst_q),
    .wen     (wen),
    .par_wen (par_wen),
    .idx     (word_idx),
    .wdata   (wr_data),
    .wmask   (wr_mask),
    .wpar    (wr_par),
    .rd_word (rd_word),
    .rd_par  (rd_par)
  );

  bram_out_stage #(
    .DW      (DW),
    .HAS_PAR (SHAPE == SHAPE_X16),
    .WMODE   (WMODE),
    .PWR_VAL (PWR_VAL),
    .SR_VAL  (SR_VAL)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_q),
    .en       (en),
    .we       (we),
    .sr       (sr),
    .old_data (rd_lane),
    .old_par  (rd_lane_par),
    .new_data (din),
    .new_par  (wr_par),
    .dout     (dout),
    .pout     (pout)
  );

endmodule

// File: rtl/bram_cfg_chk.sv
module bram_cfg_chk
  import bram_cfg_pkg::*;
#(
  parameter shape_e           SHAPE  = SHAPE_X16,
  parameter wmode_e           WMODE  = WM_WRITE_FIRST,
  parameter logic [REG_W-1:0] SR_VAL = '0,
  localparam int DW = data_w(SHAPE)
) (
  input logic             clk,
  input logic             rst_q,
  input logic             en,
  input logic             we,
  input logic             sr,
  input logic [DW-1:0]    din,
  input logic [PAR_W-1:0] pin,
  input logic [DW-1:0]    dout,
  input logic [PAR_W-1:0] pout,
  input logic [DW-1:0]    rd_lane,
  input logic [PAR_W-1:0] rd_lane_par
);

  localparam bit WIDE = (SHAPE == SHAPE_X16);

  p_read_path_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (en && !we && !sr) |=> (dout == $past(rd_lane)) && (!WIDE || pout == $past(rd_lane_par)));

  p_write_first_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (WMODE == WM_WRITE_FIRST && en && we && !sr) |=>
      (dout == $past(din)) && (!WIDE || pout == $past(pin)));

  p_read_first_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (WMODE == WM_READ_FIRST && en && we && !sr) |=> dout == $past(rd_lane));

  p_no_change_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (WMODE == WM_NO_CHANGE && en && we && !sr) |=> $stable(dout) && $stable(pout));

  p_sr_value_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (en && sr) |=> (dout == SR_VAL[DW-1:0]) && (!WIDE || pout == SR_VAL[REG_W-1:PHYS_W]));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !en |=> $stable(dout) && $stable(pout));

  p_narrow_parity_r10: assert property (@(posedge clk) disable iff (!rst_q)
    !WIDE |-> pout == '0);

endmodule

bind bram_cfg bram_cfg_chk #(.SHAPE(SHAPE), .WMODE(WMODE), .SR_VAL(SR_VAL)) u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .en          (en),
  .we          (we),
  .sr          (sr),
  .din         (din),
  .pin         (pin),
  .dout        (dout),
  .pout        (pout),
  .rd_lane     (rd_lane),
  .rd_lane_par (rd_lane_par)
);

// File: tb/bram_cfg_test.sv
`timescale 1ns/1ps
module bram_cfg_test;
  import bram_cfg_pkg::*;

  localparam real CLK_NS = 8.0;

  typedef logic [INIT_WORDS-1:0][INIT_WORD_W-1:0]  initd_t;
  typedef logic [PINIT_WORDS-1:0][INIT_WORD_W-1:0] initp_t;

  function automatic logic [15:0] pat16(int w);
    return 16'(w * 40503 + 4660);
  endfunction

  function automatic logic [1:0] patp(int w);
    return 2'(w ^ (w >> 3));
  endfunction

  function automatic initd_t make_initd();
    logic [TOTAL_BITS-1:0] f;
    for (int w = 0; w < PHYS_DEPTH; w++) f[w*16 +: 16] = pat16(w);
    return f;
  endfunction

  function automatic initp_t make_initp();
    logic [PHYS_DEPTH*2-1:0] f;
    for (int w = 0; w < PHYS_DEPTH; w++) f[w*2 +: 2] = patp(w);
    return f;
  endfunction

  localparam initd_t TB_INITD = make_initd();
  localparam initp_t TB_INITP = make_initp();

  logic clk = 1'b0;
  logic rst_n, en, we, sr;
  logic [13:0] a14;
  logic [15:0] d16;
  logic [1:0]  p2;
  logic [15:0] q16;
  logic [3:0]  q4;
  logic        q1;
  logic [1:0]  qp16, qp4, qp1;

  always #(CLK_NS/2) clk = ~clk;

  bram_cfg #(.SHAPE(SHAPE_X16), .WMODE(WM_WRITE_FIRST), .PWR_VAL(18'h2BEEF),
             .SR_VAL(18'h10F0F), .INIT_DATA(TB_INITD), .INIT_PAR(TB_INITP)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .sr(sr), .addr(a14[9:0]),
    .din(d16), .pin(p2), .dout(q16), .pout(qp16));

  bram_cfg #(.SHAPE(SHAPE_X4), .WMODE(WM_READ_FIRST), .PWR_VAL(18'h00005),
             .SR_VAL(18'h0000A), .INIT_DATA(TB_INITD), .INIT_PAR(TB_INITP)) uut_rf (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .sr(sr), .addr(a14[11:0]),
    .din(d16[3:0]), .pin(p2), .dout(q4), .pout(qp4));

  bram_cfg #(.SHAPE(SHAPE_X1), .WMODE(WM_NO_CHANGE), .PWR_VAL(18'h00001),
             .SR_VAL(18'h00000), .INIT_DATA(TB_INITD), .INIT_PAR(TB_INITP)) uut_nc (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .sr(sr), .addr(a14),
    .din(d16[0]), .pin(p2), .dout(q1), .pout(qp1));

  // bench-side contents, one array per instance
  logic [15:0] sm16 [PHYS_DEPTH];
  logic [1:0]  smp  [PHYS_DEPTH];
  logic [15:0] sm4  [PHYS_DEPTH];
  logic [15:0] sm1  [PHYS_DEPTH];
  logic [15:0] e16;
  logic [1:0]  ep;
  logic [3:0]  e4;
  logic        e1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct packed {
    logic [3:0]  rq;
    logic        en;
    logic        we;
    logic        sr;
    logic [13:0] a;
    logic [15:0] d;
    logic [1:0]  p;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    {4'd3,  1'b1, 1'b0, 1'b0, 14'h0000, 16'h0000, 2'd0},  // R3 read bottom
    {4'd3,  1'b1, 1'b0, 1'b0, 14'h3FFF, 16'h0000, 2'd0},  // R3 read top
    {4'd4,  1'b1, 1'b1, 1'b0, 14'h0123, 16'hA5C3, 2'd1},  // write: R4 R5 R6
    {4'd3,  1'b1, 1'b0, 1'b0, 14'h0123, 16'h0000, 2'd0},  // readback
    {4'd5,  1'b1, 1'b1, 1'b0, 14'h0123, 16'h5A3C, 2'd2},  // overwrite
    {4'd3,  1'b1, 1'b0, 1'b0, 14'h0123, 16'h0000, 2'd0},
    {4'd8,  1'b0, 1'b1, 1'b1, 14'h0123, 16'hFFFF, 2'd3},  // R8 disabled write+sr
    {4'd8,  1'b1, 1'b0, 1'b0, 14'h0123, 16'h0000, 2'd0},  // R8 nothing stored
    {4'd7,  1'b1, 1'b0, 1'b1, 14'h0200, 16'h0000, 2'd0},  // R7 sr over read
    {4'd7,  1'b1, 1'b1, 1'b1, 14'h0200, 16'h1357, 2'd3},  // R7 sr with write
    {4'd7,  1'b1, 1'b0, 1'b0, 14'h0200, 16'h0000, 2'd0},  // R7 write was stored
    {4'd6,  1'b1, 1'b1, 1'b0, 14'h2AAA, 16'h0001, 2'd0},
    {4'd3,  1'b1, 1'b0, 1'b0, 14'h2AAA, 16'h0000, 2'd0},
    {4'd3,  1'b1, 1'b0, 1'b0, 14'h1555, 16'h0000, 2'd0},
    {4'd8,  1'b0, 1'b0, 1'b0, 14'h0000, 16'h0000, 2'd0},  // R8 idle hold
    {4'd6,  1'b1, 1'b1, 1'b0, 14'h3FFE, 16'h7FFF, 2'd1},
    {4'd10, 1'b1, 1'b0, 1'b0, 14'h3FFE, 16'h0000, 2'd0}   // R10 parity readback
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic load_shadow();
    for (int w = 0; w < PHYS_DEPTH; w++) begin
      sm16[w] = pat16(w);
      smp[w]  = patp(w);
      sm4[w]  = pat16(w);
      sm1[w]  = pat16(w);
    end
    e16 = 16'hBEEF; ep = 2'b10; e4 = 4'h5; e1 = 1'b1;
  endtask

  // expected outputs for the edge about to happen on the driven inputs
  task automatic model_step();
    int i16, w4, l4, w1, l1;
    if (en) begin
      i16 = int'(a14[9:0]);
      if (sr) begin e16 = 16'h0F0F; ep = 2'b01; end
      else if (!we) begin e16 = sm16[i16]; ep = smp[i16]; end
      else begin e16 = d16; ep = p2; end
      if (we) begin sm16[i16] = d16; smp[i16] = p2; end

      w4 = int'(a14[11:2]); l4 = int'(a14[1:0]);
      e4 = sr ? 4'hA : sm4[w4][l4*4 +: 4];
      if (we) sm4[w4][l4*4 +: 4] = d16[3:0];

      w1 = int'(a14[13:4]); l1 = int'(a14[3:0]);
      if (sr) e1 = 1'b0;
      else if (!we) e1 = sm1[w1][l1];
      if (we) sm1[w1][l1] = d16[0];
    end
  endtask

  task automatic check_all(string t16, string t4, string t1);
    check(t16, 32'(q16), 32'(e16));
    check(t16, 32'(qp16), 32'(ep));
    check(t4, 32'(q4), 32'(e4));
    check("R10", 32'(qp4), 32'd0);
    check(t1, 32'(q1), 32'(e1));
    check("R10", 32'(qp1), 32'd0);
  endtask

  // drive on a falling edge, let one rising edge pass, compare at the next fall
  task automatic do_op(logic e, logic w, logic s, logic [13:0] a, logic [15:0] d, logic [1:0] p,
                       string t16, string t4, string t1);
    en = e; we = w; sr = s; a14 = a; d16 = d; p2 = p;
    model_step();
    @(negedge clk);
    check_all(t16, t4, t1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 190000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; we = 1'b0; sr = 1'b0;
    a14 = '0; d16 = '0; p2 = '0;
    load_shadow();
    #20;
    // R9 power-up value during reset
    check_all("R9", "R9", "R9");

    // R1 shape widths
    check("R1", $bits(uut.addr), 10);
    check("R1", $bits(uut_rf.addr), 12);
    check("R1", $bits(uut_nc.addr), 14);
    check("R1", $bits(uut.dout) + $bits(uut_rf.dout) + $bits(uut_nc.dout), 21);
    check("R1", $bits(uut.pout), 2);

    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 value held after release until an enabled edge
    check_all("R9", "R9", "R9");

    // R2 preload sweep over every 1-bit entry
    for (int a = 0; a < TOTAL_BITS; a++) begin
      do_op(1'b1, 1'b0, 1'b0, 14'(a), 16'h0, 2'd0, "R2", "R2", "R2");
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      vec_t cv;
      string tg;
      cv = VECS[v];
      tg = $sformatf("R%0d", cv.rq);
      if (cv.en && cv.we && !cv.sr)
        do_op(cv.en, cv.we, cv.sr, cv.a, cv.d, cv.p, "R4", "R5", "R6");
      else
        do_op(cv.en, cv.we, cv.sr, cv.a, cv.d, cv.p, tg, tg, tg);
    end

    // R6 no-change hold across back-to-back writes
    do_op(1'b1, 1'b0, 1'b0, 14'h0777, 16'h0, 2'd0, "R3", "R3", "R3");
    do_op(1'b1, 1'b1, 1'b0, 14'h0777, 16'hFFFF, 2'd3, "R4", "R5", "R6");
    do_op(1'b1, 1'b1, 1'b0, 14'h0778, 16'h0000, 2'd0, "R4", "R5", "R6");
    do_op(1'b1, 1'b0, 1'b0, 14'h0777, 16'h0, 2'd0, "R10", "R3", "R3");

    // R9 mid-run reset: immediate power-up value, contents restored
    en = 1'b0; we = 1'b0; sr = 1'b0;
    rst_n = 1'b0;
    #2;
    load_shadow();
    check_all("R9", "R9", "R9");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R9", "R9", "R9");
    do_op(1'b1, 1'b0, 1'b0, 14'h0123, 16'h0, 2'd0, "R9", "R9", "R9");
    do_op(1'b1, 1'b0, 1'b0, 14'h0200, 16'h0, 2'd0, "R9", "R9", "R9");
    do_op(1'b1, 1'b0, 1'b0, 14'h3FFE, 16'h0, 2'd0, "R9", "R9", "R9");

    finish_run();
  end

endmodule